// File: doc/BRIEF.md
# ATA PIO Host Cycle Timer

This block drives one programmed-I/O transfer on the host side of a parallel ATA bus. A single-cycle start pulse latches the timing mode (0 to 6), the access width (16-bit data word or 8-bit task-file register), the direction, the register address and the write data. The block then sequences the address phase, the read or write strobe and the recovery phase, with every phase length taken from per-mode nanosecond minimums. Each minimum is converted at elaboration to whole clock periods (rounded up, never less than one).

The device may stretch the strobe by pulling the ready line low. That line passes through a two-flop synchronizer and is examined a fixed 35 ns after the strobe falls, in modes 0 to 4 only. A wait that lasts longer than 1250 ns is abandoned with a timeout flag. Recovery is lengthened whenever the address phase plus the actual strobe time would otherwise fall short of the mode's minimum total cycle.

States: IDLE (bus released), SETUP (address and chip select driven, strobes high), STROBE (strobe low for the minimum active time), HOLDOFF (strobe held low while the device is not ready), RECOVER (strobes high, address and write data still held) and FINISH (one-cycle done). Transitions: IDLE to SETUP on start. SETUP to STROBE when the address time ends. STROBE to HOLDOFF when ready is low at the sample point. STROBE to RECOVER when the active minimum is met. HOLDOFF to RECOVER on ready high with the active minimum met, or when the wait limit expires. RECOVER to FINISH when recovery ends. FINISH to IDLE always.

Top module: `pio_host_timer`

## Requirements
- R1: After reset both strobes are high, the address, chip select and data bus are not driven, and done, busy and timeout are 0.
- R2: After start, the address is driven with both strobes high for ceil(t1/8 ns) cycles, where t1 is 70, 50, 30, 30, 25, 15 or 10 ns for modes 0 to 6. The strobe that follows is the read strobe for wr=0 and the write strobe for wr=1, never both.
- R3: With the device ready, the strobe stays low for exactly ceil(t2/8 ns) cycles. For a 16-bit access t2 is 165, 125, 100, 80, 70, 65 or 55 ns in modes 0 to 6. For an 8-bit access (reg8=1) it is 290 ns in modes 0 to 2 and unchanged above.
- R4: Recovery lasts max(R, T0 - T1 - W) cycles. W is the actual strobe cycles, T0 and T1 are the cycle counts of t0 (600, 383, 240, 180, 120, 100, 80 ns) and t1. R is the largest count among recovery (modes 3 to 6: 70, 25, 25, 20 ns; one cycle for modes 0 to 2), write-data hold (30, 20, 15, 10, 10, 10, 5 ns) and address hold (20, 15, 10, then 10 ns).
- R5: Address output and chip select stay constant from the first setup cycle through the last recovery cycle. For writes, the data bus is enabled with the write data over the same span; for reads it is never enabled.
- R6: In modes 0 to 4, a ready line that is low 5 cycles after the strobe falls holds the strobe low. If ready returns high at the falling clock edge that ends the L-th strobe-low cycle (L >= 6), the strobe lasts max(T2, L+2) cycles.
- R7: In modes 5 and 6 the ready line is ignored: the strobe lasts T2 cycles even when ready stays low.
- R8: A read loads rdata with the data bus value present in the last strobe-low cycle. Writes and timed-out reads leave rdata unchanged.
- R9: If ready is still low after 157 cycles of holding (1250 ns), the strobe ends after 163 cycles in total, timeout goes to 1, and it stays 1 until the next accepted start.
- R10: done is a one-cycle pulse in the cycle after the last recovery cycle, followed by idle. busy is 1 from setup to done. A start while busy is ignored.
- R11: Mode code 7 is timed as mode 6.
- R12: When ready returns high in the very cycle the wait limit is reached, the transfer ends normally with no timeout and read data captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, 8 ns period by default |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin a transfer (ignored while busy) |
| mode | input | 3 | PIO timing mode, 7 treated as 6 |
| reg8 | input | 1 | 1 selects 8-bit register timing, 0 the 16-bit data word |
| wr | input | 1 | 1 for write, 0 for read |
| addr | input | 4 | Chip select and register address |
| wdata | input | 16 | Write data |
| iordy | input | 1 | Device ready line, asynchronous |
| dd_in | input | 16 | Data bus value from the device |
| adr_out | output | 4 | Driven chip select and address |
| adr_oe | output | 1 | Address and chip select are valid |
| dior_n | output | 1 | Read strobe, active low |
| diow_n | output | 1 | Write strobe, active low |
| dd_out | output | 16 | Data bus value driven by the host |
| dd_oe | output | 1 | Host drives the data bus |
| rdata | output | 16 | Last captured read data |
| done | output | 1 | Transfer complete pulse |
| busy | output | 1 | Transfer in progress |
| timeout | output | 1 | Last transfer ended by the wait limit |

## Verification
Two exits from HOLDOFF can fall in the same cycle: the ready line returning high and the wait limit expiring. The bench releases ready after exactly 161 strobe-low samples, so the synchronized level reaches the state machine on the final wait cycle. It expects a 163-cycle strobe, captured data and no timeout. One sample later it expects the same strobe length with timeout set and rdata unchanged. A second overlap, the ready return against the minimum active time, is covered by early releases, where the strobe must still last the full T2.

// File: rtl/pio_timer_pkg.sv
package pio_timer_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLDOFF,
        ST_RECOVER,
        ST_FINISH
    } pio_state_e;

    localparam int unsigned RDY_SAMPLE_NS = 35;
    localparam int unsigned RDY_LIMIT_NS  = 1250;
    localparam int unsigned FASTEST_MODE  = 6;
    localparam int unsigned LAST_RDY_MODE = 4;

    function automatic int unsigned ns_to_clk(input int unsigned ns, input int unsigned clk_ns);
        int unsigned c;
        c = (ns + clk_ns - 1) / clk_ns;
        if (c == 0) c = 1;
        return c;
    endfunction

    function automatic int unsigned cycle_ns(input int unsigned m);
        case (m)
            0: return 600; 1: return 383; 2: return 240; 3: return 180;
            4: return 120; 5: return 100; default: return 80;
        endcase
    endfunction

    function automatic int unsigned addr_setup_ns(input int unsigned m);
        case (m)
            0: return 70; 1: return 50; 2: return 30; 3: return 30;
            4: return 25; 5: return 15; default: return 10;
        endcase
    endfunction

    function automatic int unsigned active_ns(input int unsigned m, input logic narrow);
        if (narrow && m <= 2) return 290;
        case (m)
            0: return 165; 1: return 125; 2: return 100; 3: return 80;
            4: return 70; 5: return 65; default: return 55;
        endcase
    endfunction

    function automatic int unsigned inactive_ns(input int unsigned m);
        case (m)
            3: return 70; 4: return 25; 5: return 25; 6: return 20;
            default: return 0;
        endcase
    endfunction

    function automatic int unsigned wdata_hold_ns(input int unsigned m);
        case (m)
            0: return 30; 1: return 20; 2: return 15; 6: return 5;
            default: return 10;
        endcase
    endfunction

    function automatic int unsigned addr_hold_ns(input int unsigned m);
        case (m)
            0: return 20; 1: return 15;
            default: return 10;
        endcase
    endfunction

endpackage

// File: rtl/pio_mode_timing.sv
module pio_mode_timing
    import pio_timer_pkg::*;
#(
    parameter int unsigned CLK_NS = 8,
    parameter int unsigned CW     = 10
) (
    input  logic [2:0]    mode,
    input  logic          reg8,
    output logic [CW-1:0] total_c,
    output logic [CW-1:0] setup_c,
    output logic [CW-1:0] active_c,
    output logic [CW-1:0] recmin_c,
    output logic          rdy_en
);
    int unsigned m;
    int unsigned r;

    always_comb begin
        m = (int'(mode) > int'(FASTEST_MODE)) ? FASTEST_MODE : int'(mode);
        total_c  = CW'(ns_to_clk(cycle_ns(m), CLK_NS));
        setup_c  = CW'(ns_to_clk(addr_setup_ns(m), CLK_NS));
        active_c = CW'(ns_to_clk(active_ns(m, reg8), CLK_NS));
        r = ns_to_clk(inactive_ns(m), CLK_NS);
        if (ns_to_clk(wdata_hold_ns(m), CLK_NS) > r) r = ns_to_clk(wdata_hold_ns(m), CLK_NS);
        if (ns_to_clk(addr_hold_ns(m), CLK_NS) > r) r = ns_to_clk(addr_hold_ns(m), CLK_NS);
        recmin_c = CW'(r);
        rdy_en   = (m <= LAST_RDY_MODE);
    end
endmodule

// File: rtl/pio_rdy_sync.sv
module pio_rdy_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '1;
                else        chain <= din;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '1;
                else        chain <= {chain[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/pio_host_timer.sv
module pio_host_timer
    import pio_timer_pkg::*;
#(
    parameter int unsigned CLK_NS = 8,
    parameter int unsigned CW     = 10,
    parameter int unsigned AW     = 4,
    parameter int unsigned DW     = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [2:0]    mode,
    input  logic          reg8,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          iordy,
    input  logic [DW-1:0] dd_in,
    output logic [AW-1:0] adr_out,
    output logic          adr_oe,
    output logic          dior_n,
    output logic          diow_n,
    output logic [DW-1:0] dd_out,
    output logic          dd_oe,
    output logic [DW-1:0] rdata,
    output logic          done,
    output logic          busy,
    output logic          timeout
);
    localparam int unsigned SAMPLE_C = ns_to_clk(RDY_SAMPLE_NS, CLK_NS);
    localparam int unsigned LIMIT_C  = ns_to_clk(RDY_LIMIT_NS, CLK_NS);
    localparam logic [CW-1:0] SAMPLE_AT  = CW'(SAMPLE_C);
    localparam logic [CW-1:0] LIMIT_LAST = CW'(LIMIT_C - 1);

    pio_state_e    state, nxt;
    logic [CW-1:0] cnt, wcnt;
    logic [2:0]    mode_q;
    logic          reg8_q, wr_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic          rdy_s;
    logic [CW-1:0] total_c, setup_c, active_c, recmin_c;
    logic          rdy_en;

    logic [CW:0]          act;
    logic                 min_met;
    logic signed [CW+1:0] need;
    logic [CW-1:0]        rec_len;
    logic                 go_rec, limit_hit;

    pio_mode_timing #(.CLK_NS(CLK_NS), .CW(CW)) u_timing (
        .mode(mode_q), .reg8(reg8_q), .total_c(total_c), .setup_c(setup_c),
        .active_c(active_c), .recmin_c(recmin_c), .rdy_en(rdy_en)
    );

    pio_rdy_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(iordy), .dout(rdy_s)
    );

    always_comb begin
        act     = {1'b0, cnt} + (CW+1)'(1);
        min_met = act >= {1'b0, active_c};
        need    = $signed({2'b00, total_c}) - $signed({2'b00, setup_c}) - $signed({1'b0, act});
        rec_len = (need > $signed({2'b00, recmin_c})) ? need[CW-1:0] : recmin_c;
    end

    always_comb begin
        nxt       = state;
        limit_hit = 1'b0;
        unique case (state)
            ST_IDLE:    if (start) nxt = ST_SETUP;
            ST_SETUP:   if (cnt == setup_c - CW'(1)) nxt = ST_STROBE;
            ST_STROBE: begin
                if (rdy_en && cnt == SAMPLE_AT && !rdy_s)
                    nxt = ST_HOLDOFF;
                else if (min_met && (!rdy_en || cnt >= SAMPLE_AT))
                    nxt = ST_RECOVER;
            end
            ST_HOLDOFF: begin
                if (rdy_s && min_met) nxt = ST_RECOVER;
                else if (wcnt == LIMIT_LAST) begin
                    nxt       = ST_RECOVER;
                    limit_hit = 1'b1;
                end
            end
            ST_RECOVER: if (cnt == '0) nxt = ST_FINISH;
            ST_FINISH:  nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
        go_rec = (state == ST_STROBE || state == ST_HOLDOFF) && nxt == ST_RECOVER;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0; wcnt <= '0; mode_q <= '0; reg8_q <= 1'b0; wr_q <= 1'b0;
            addr_q <= '0; wdata_q <= '0; rdata <= '0; timeout <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    mode_q <= mode; reg8_q <= reg8; wr_q <= wr;
                    addr_q <= addr; wdata_q <= wdata;
                    cnt <= '0; timeout <= 1'b0;
                end
                ST_SETUP: cnt <= (nxt == ST_STROBE) ? '0 : cnt + CW'(1);
                ST_STROBE, ST_HOLDOFF: begin
                    wcnt <= (state == ST_HOLDOFF) ? wcnt + CW'(1) : '0;
                    if (go_rec) begin
                        cnt <= rec_len - CW'(1);
                        if (limit_hit) timeout <= 1'b1;
                        else if (!wr_q) rdata <= dd_in;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                ST_RECOVER: cnt <= cnt - CW'(1);
                default: ;
            endcase
        end
    end

    always_comb begin
        adr_oe  = (state == ST_SETUP) || (state == ST_STROBE) ||
                  (state == ST_HOLDOFF) || (state == ST_RECOVER);
        adr_out = addr_q;
        dior_n  = !((state == ST_STROBE || state == ST_HOLDOFF) && !wr_q);
        diow_n  = !((state == ST_STROBE || state == ST_HOLDOFF) && wr_q);
        dd_out  = wdata_q;
        dd_oe   = adr_oe && wr_q;
        done    = (state == ST_FINISH);
        busy    = (state != ST_IDLE);
    end
endmodule

// File: rtl/pio_timer_chk.sv
module pio_timer_chk #(
    parameter int unsigned AW = 4,
    parameter int unsigned DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] adr_out,
    input logic          adr_oe,
    input logic          dior_n,
    input logic          diow_n,
    input logic [DW-1:0] dd_out,
    input logic          dd_oe,
    input logic          done,
    input logic          timeout
);
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!dior_n && !diow_n)); // R2
    AST_ADDR_UNDER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (!dior_n || !diow_n) |-> adr_oe); // R5
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (adr_oe && $past(adr_oe)) |-> ($stable(adr_out) && $stable(dd_out))); // R5
    AST_WRITE_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !diow_n |-> dd_oe); // R5
    AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !dior_n |-> !dd_oe); // R5
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !adr_oe)); // R10
    AST_TIMEOUT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout) |-> (dior_n && diow_n && adr_oe)); // R9
endmodule

bind pio_host_timer pio_timer_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .adr_out(adr_out), .adr_oe(adr_oe),
    .dior_n(dior_n), .diow_n(diow_n), .dd_out(dd_out), .dd_oe(dd_oe),
    .done(done), .timeout(timeout)
);

// File: tb/tb_pio_host_timer.sv
module tb_pio_host_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  mode = '0;
    logic        reg8 = 1'b0;
    logic        wr = 1'b0;
    logic [3:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic        iordy = 1'b1;
    logic [15:0] dd_in = '0;
    logic [3:0]  adr_out;
    logic        adr_oe, dior_n, diow_n, dd_oe, done, busy, timeout;
    logic [15:0] dd_out, rdata;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic [15:0] last_rd = '0;

    localparam int T0N[7]  = '{600, 383, 240, 180, 120, 100, 80};
    localparam int T1N[7]  = '{70, 50, 30, 30, 25, 15, 10};
    localparam int T2N[7]  = '{165, 125, 100, 80, 70, 65, 55};
    localparam int T2IN[7] = '{0, 0, 0, 70, 25, 25, 20};
    localparam int T4N[7]  = '{30, 20, 15, 10, 10, 10, 5};
    localparam int T9N[7]  = '{20, 15, 10, 10, 10, 10, 10};
    localparam int LIMIT_W = 163;

    pio_host_timer dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .reg8(reg8), .wr(wr),
        .addr(addr), .wdata(wdata), .iordy(iordy), .dd_in(dd_in), .adr_out(adr_out),
        .adr_oe(adr_oe), .dior_n(dior_n), .diow_n(diow_n), .dd_out(dd_out),
        .dd_oe(dd_oe), .rdata(rdata), .done(done), .busy(busy), .timeout(timeout)
    );

    always #4 clk = ~clk;

    function automatic int cyc_of(input int ns);
        int c;
        c = (ns + 7) / 8;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic run_txn(input int m, input bit r8, input bit w, input logic [3:0] a,
                           input logic [15:0] wd, input logic [15:0] din, input int rel,
                           input bit poke);
        int em, t1, t2, t0, rmin, w_exp, rec_exp, n_set, n_str, n_rec, phase;
        bit to_exp, kind_bad, drive_bad, seen_done;
        em = (m > 6) ? 6 : m;
        t0 = cyc_of(T0N[em]);
        t1 = cyc_of(T1N[em]);
        t2 = cyc_of((r8 && em <= 2) ? 290 : T2N[em]);
        rmin = imax(cyc_of(T2IN[em]), imax(cyc_of(T4N[em]), cyc_of(T9N[em])));
        to_exp = 1'b0;
        if (em >= 5 || rel < 0) w_exp = t2;
        else if (rel + 2 > LIMIT_W) begin w_exp = LIMIT_W; to_exp = 1'b1; end
        else w_exp = imax(t2, rel + 2);
        rec_exp = imax(rmin, t0 - t1 - w_exp);

        @(negedge clk);
        mode <= 3'(m); reg8 <= r8; wr <= w; addr <= a; wdata <= wd; dd_in <= din;
        iordy <= (rel < 0); start <= 1'b1;
        @(negedge clk);
        start <= 1'b0;
        n_set = 0; n_str = 0; n_rec = 0; phase = 0;
        kind_bad = 0; drive_bad = 0; seen_done = 0;
        for (int k = 0; k < 3000; k++) begin
            if (done) begin seen_done = 1; break; end
            start <= 1'b0;
            if (adr_oe) begin
                if (adr_out != a || dd_oe != w || !busy) drive_bad = 1;
                if (w && dd_out != wd) drive_bad = 1;
            end
            if (!dior_n || !diow_n) begin
                n_str++;
                if (w ? !dior_n : !diow_n) kind_bad = 1;
                if (phase == 2) kind_bad = 1;
                phase = 1;
                if (rel >= 0 && n_str == rel) iordy <= 1'b1;
                if (poke && n_str == 2) begin start <= 1'b1; addr <= ~a; end
            end else if (adr_oe) begin
                if (phase == 0) n_set++;
                else begin phase = 2; n_rec++; end
            end
            @(negedge clk);
        end
        chk(seen_done, "R10", "done seen", seen_done, 1);
        chk(n_set == t1, "R2", "setup cycles", n_set, t1);
        chk(!kind_bad, "R2", "strobe kind/order", kind_bad, 0);
        chk(n_str == w_exp, (em >= 5) ? "R7" : ((rel >= 0) ? "R6" : "R3"), "strobe cycles", n_str, w_exp);
        chk(n_rec == rec_exp, "R4", "recovery cycles", n_rec, rec_exp);
        chk(!drive_bad, "R5", "address/data drive", drive_bad, 0);
        chk(timeout == to_exp, (rel == 161) ? "R12" : "R9", "timeout flag", timeout, to_exp);
        if (!w && !to_exp) last_rd = din;
        chk(rdata == last_rd, "R8", "read data", rdata, last_rd);
        iordy <= 1'b1;
        @(negedge clk);
        chk(!done && !adr_oe && !busy, "R10", "done single pulse then idle", done, 0);
        if (poke) begin
            for (int k = 0; k < 4; k++) begin
                chk(!adr_oe && !busy, "R10", "start while busy ignored", adr_oe, 0);
                @(negedge clk);
            end
        end
        chk(timeout == to_exp, "R9", "timeout held until next start", timeout, to_exp);
        repeat (3) @(negedge clk);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        chk(dior_n && diow_n && !adr_oe && !dd_oe && !done && !busy && !timeout,
            "R1", "reset outputs", {dior_n, diow_n, adr_oe, dd_oe, done, busy, timeout}, 7'b1100000);
        rst_n <= 1'b1;
        repeat (2) @(negedge clk);
        chk(dior_n && diow_n && !adr_oe && !busy, "R1", "idle after reset", adr_oe, 0);

        run_txn(0, 0, 0, 4'h1, 16'h0000, 16'hA5C3, -1, 0);   // R3 mode 0 word read
        run_txn(0, 1, 1, 4'h7, 16'h00E1, 16'h0000, -1, 0);   // R3 8-bit 290 ns
        run_txn(2, 1, 0, 4'h3, 16'h0000, 16'h1234, -1, 0);   // R3
        run_txn(3, 0, 1, 4'h0, 16'hBEEF, 16'h0000, -1, 0);   // R4 recovery floor
        run_txn(4, 0, 0, 4'h5, 16'h0000, 16'h5A5A, 20, 0);   // R6 wait
        run_txn(0, 0, 0, 4'h6, 16'h0000, 16'h0F0F, 6, 0);    // R6 early release
        run_txn(5, 0, 0, 4'h2, 16'h0000, 16'h3C3C, 30, 0);   // R7 ready ignored
        run_txn(6, 1, 1, 4'h9, 16'h0042, 16'h0000, 50, 0);   // R7
        run_txn(7, 0, 0, 4'hA, 16'h0000, 16'h7777, -1, 0);   // R11
        run_txn(1, 0, 0, 4'hB, 16'h0000, 16'h9999, 100000, 0); // R9 timeout
        run_txn(3, 0, 0, 4'hC, 16'h0000, 16'h8181, 161, 0);  // R12 same-cycle
        run_txn(3, 0, 0, 4'hD, 16'h0000, 16'h4242, 162, 0);  // R9 one later
        run_txn(2, 0, 1, 4'hE, 16'hCAFE, 16'h0000, -1, 1);   // R10 start ignored

        for (int i = 0; i < 30; i++) begin
            int rm, rl;
            rm = int'($urandom_range(0, 7));
            rl = ($urandom_range(0, 2) == 0) ? -1 : int'($urandom_range(6, 60));
            run_txn(rm, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                    4'($urandom_range(0, 15)), 16'($urandom), 16'($urandom), rl, 0);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule